// File: doc/BRIEF.md
# Photon Detector Quench-Recharge Sequencer

This block runs the detection cycle of one Geiger-mode photodiode channel from a fast clock. The channel goes through a fixed loop. A short recharge pulls the diode node back to the supply. The node is then left floating and armed. When the threshold comparator reports an avalanche, the quench switch closes after a programmable reaction delay and stays closed for a recovery interval. After that the loop returns to recharge. Every duration is a parameter counted in clock cycles. With a 0.5 ns clock the defaults give a 3-cycle recharge and a 13-cycle recovery.

The comparator output arrives without any timing relation to the clock, so it goes through a synchroniser of parameterised depth. That synchroniser is flushed for as long as the recharge switch is closed, so a detection during recharge can never register. Each avalanche seen while armed gives exactly one single-cycle event pulse. A busy flag marks every cycle in which the channel cannot see photons, so downstream logic can correct its count statistics for dead time. All outputs come straight from flip-flops.

Top module: `qrs_sequencer`

## Requirements
- R1: While `rst_i` is high, `load_en_o`=1, `quench_en_o`=0, `event_o`=0 and `busy_o`=1, whatever `det_i` does.
- R2: After reset is released, `load_en_o` stays high for RECHARGE_CYC cycles in total, counting the last reset cycle. It then falls in the same cycle that `busy_o` falls, and the channel is armed.
- R3: `load_en_o` and `quench_en_o` are never high in the same cycle.
- R4: While armed, a high `det_i` gives `event_o` high for exactly one cycle, SYNC_STAGES+1 cycles after the first armed cycle in which `det_i` was high.
- R5: `busy_o` is high in the cycle of the event pulse. `quench_en_o` rises REACT_CYC cycles after the event cycle, and `load_en_o` stays low meanwhile.
- R6: `quench_en_o` stays high for exactly RECOVER_CYC cycles. `load_en_o` goes high in the cycle right after it falls.
- R7: The channel re-arms (`busy_o`=0, both enables low) REACT_CYC+RECOVER_CYC+RECHARGE_CYC cycles after the event cycle.
- R8: A `det_i` pulse during recharge (`load_en_o` high) that ends before arming produces no event. The channel is still armed and idle afterwards.
- R9: A `det_i` pulse during the reaction delay or the quench produces no event. It also leaves nothing behind that could trigger after re-arming.
- R10: If `det_i` is held high, the channel fires again after each re-arm. Successive events are spaced REACT_CYC+RECOVER_CYC+RECHARGE_CYC+SYNC_STAGES+1 cycles apart.
- R11: `busy_o` is low only while armed, and whenever `busy_o` is low both switch enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_i | input | 1 | Synchronous active-high reset |
| det_i | input | 1 | Comparator detect level, not related to the clock |
| load_en_o | output | 1 | Recharge switch enable |
| quench_en_o | output | 1 | Quench switch enable |
| event_o | output | 1 | One-cycle pulse per registered avalanche |
| busy_o | output | 1 | Channel blind (not armed) |

## Verification
The assertions assume that `rst_i` is synchronous and held for at least one clock edge. They also assume that `det_i` is a plain level, so the assertions place no conditions on it. Every duration assertion counts cycles relative to the switch enables themselves. In the bench, `det_i` changes only on falling clock edges, so each rising edge samples a stable value. Detections are placed at cycle offsets computed from the event cycle, so that every pulse meant to be ignored falls inside the recharge window or the quench window.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
  typedef enum logic [1:0] {
    ST_CHARGE = 2'd0,
    ST_ARMED  = 2'd1,
    ST_REACT  = 2'd2,
    ST_QUENCH = 2'd3
  } qrs_state_e;

  function automatic int qrs_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/qrs_det_sync.sv
// Detect-level synchroniser; every stage is flushed while clr_i is high.
module qrs_det_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic det_i,
  output logic det_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign det_o = det_i & ~clr_i;
    end else begin : g_chain
      logic [STAGES-1:0] stg_q;
      always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) stg_q <= '0;
        else                stg_q <= {stg_q[STAGES-2+((STAGES==1)?1:0):0], det_i};
      end
      assign det_o = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/qrs_interval_timer.sv
// Down counter: loaded with (duration-1), done when it reads zero.
module qrs_interval_timer #(
  parameter int W        = 4,
  parameter int INIT_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)              cnt_q <= W'(INIT_VAL);
    else if (ld_i)          cnt_q <= ld_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/qrs_ctrl.sv
// State sequencing and registered switch / status outputs.
module qrs_ctrl
  import qrs_pkg::*;
#(
  parameter int RECHARGE_CYC = 3,
  parameter int REACT_CYC    = 1,
  parameter int RECOVER_CYC  = 13,
  parameter int CNT_W        = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             det_s_i,
  input  logic             tmr_done_i,
  output logic             tmr_ld_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             load_o,
  output logic             quench_o,
  output logic             event_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] RCH_LD = CNT_W'(RECHARGE_CYC - 1);
  localparam logic [CNT_W-1:0] RCT_LD = CNT_W'((REACT_CYC > 0) ? REACT_CYC - 1 : 0);
  localparam logic [CNT_W-1:0] RCV_LD = CNT_W'(RECOVER_CYC - 1);
  localparam qrs_state_e AFTER_HIT = (REACT_CYC > 0) ? ST_REACT : ST_QUENCH;

  qrs_state_e st_q, st_d;
  logic load_q, quench_q, event_q, busy_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_CHARGE: if (tmr_done_i) st_d = ST_ARMED;
      ST_ARMED:  if (det_s_i)    st_d = AFTER_HIT;
      ST_REACT:  if (tmr_done_i) st_d = ST_QUENCH;
      ST_QUENCH: if (tmr_done_i) st_d = ST_CHARGE;
      default:                   st_d = ST_CHARGE;
    endcase
  end

  always_comb begin
    tmr_ld_o  = (st_d != st_q);
    unique case (st_d)
      ST_CHARGE: tmr_val_o = RCH_LD;
      ST_REACT:  tmr_val_o = RCT_LD;
      ST_QUENCH: tmr_val_o = RCV_LD;
      default:   tmr_val_o = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q     <= ST_CHARGE;
      load_q   <= 1'b1;
      quench_q <= 1'b0;
      event_q  <= 1'b0;
      busy_q   <= 1'b1;
    end else begin
      st_q     <= st_d;
      load_q   <= (st_d == ST_CHARGE);
      quench_q <= (st_d == ST_QUENCH);
      event_q  <= (st_q == ST_ARMED) && det_s_i;
      busy_q   <= (st_d != ST_ARMED);
    end
  end

  assign load_o   = load_q;
  assign quench_o = quench_q;
  assign event_o  = event_q;
  assign busy_o   = busy_q;
endmodule

// File: rtl/qrs_sequencer.sv
module qrs_sequencer
  import qrs_pkg::*;
#(
  parameter int RECHARGE_CYC = 3,
  parameter int REACT_CYC    = 1,
  parameter int RECOVER_CYC  = 13,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic det_i,
  output logic load_en_o,
  output logic quench_en_o,
  output logic event_o,
  output logic busy_o
);
  localparam int MAX_CYC = qrs_max3(RECHARGE_CYC, REACT_CYC, RECOVER_CYC);
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic             det_s;
  logic             tmr_ld, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  qrs_det_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .clr_i (load_en_o),
    .det_i (det_i),
    .det_o (det_s)
  );

  qrs_interval_timer #(.W(CNT_W), .INIT_VAL(RECHARGE_CYC - 1)) u_tmr (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .ld_i     (tmr_ld),
    .ld_val_i (tmr_val),
    .done_o   (tmr_done)
  );

  qrs_ctrl #(
    .RECHARGE_CYC (RECHARGE_CYC),
    .REACT_CYC    (REACT_CYC),
    .RECOVER_CYC  (RECOVER_CYC),
    .CNT_W        (CNT_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .det_s_i    (det_s),
    .tmr_done_i (tmr_done),
    .tmr_ld_o   (tmr_ld),
    .tmr_val_o  (tmr_val),
    .load_o     (load_en_o),
    .quench_o   (quench_en_o),
    .event_o    (event_o),
    .busy_o     (busy_o)
  );
endmodule

// File: rtl/qrs_sequencer_chk.sv
module qrs_sequencer_chk #(
  parameter int RECHARGE_CYC = 3,
  parameter int RECOVER_CYC  = 13
) (
  input logic clk_i,
  input logic rst_i,
  input logic load_en_o,
  input logic quench_en_o,
  input logic event_o,
  input logic busy_o
);
  int unsigned ld_run, qn_run;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ld_run <= 0;
      qn_run <= 0;
    end else begin
      ld_run <= load_en_o   ? ld_run + 1 : 0;
      qn_run <= quench_en_o ? qn_run + 1 : 0;
    end
  end

  // R1
  always @(negedge clk_i)
    if (rst_i) reset_state_chk: assert (!event_o && !quench_en_o);

  // R3
  switch_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(load_en_o && quench_en_o));

  // R4
  event_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    event_o |=> !event_o);

  // R4
  event_from_armed_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    event_o |-> $past(!busy_o));

  // R5
  event_busy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    event_o |-> busy_o);

  // R2
  recharge_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(load_en_o) |-> (ld_run == RECHARGE_CYC) && !busy_o);

  // R6
  recover_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(quench_en_o) |-> (qn_run == RECOVER_CYC) && load_en_o);

  // R11
  armed_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy_o |-> !load_en_o && !quench_en_o);
endmodule

bind qrs_sequencer qrs_sequencer_chk #(
  .RECHARGE_CYC (RECHARGE_CYC),
  .RECOVER_CYC  (RECOVER_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .load_en_o   (load_en_o),
  .quench_en_o (quench_en_o),
  .event_o     (event_o),
  .busy_o      (busy_o)
);

// File: tb/sim_qrs_sequencer.sv
`timescale 1ns/1ps
module sim_qrs_sequencer;
  localparam int RCH  = 3;
  localparam int RCT  = 1;
  localparam int RCV  = 13;
  localparam int SYN  = 2;
  localparam int LAT  = SYN + 1;
  localparam int DEAD = RCT + RCV + RCH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic det = 1'b0;
  logic load_en, quench_en, evt, busy;
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  int   exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  qrs_sequencer #(.RECHARGE_CYC(RCH), .REACT_CYC(RCT), .RECOVER_CYC(RCV), .SYNC_STAGES(SYN)) u0 (
    .clk_i(clk), .rst_i(rst), .det_i(det),
    .load_en_o(load_en), .quench_en_o(quench_en), .event_o(evt), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wait_armed();
    while (busy) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (load_en && quench_en) chk(0, "R3 both enables", 1, 0);
      if (evt) begin
        if (exp_q.size() == 0) chk(0, "R8 R9 unexpected event", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(cyc == e, "R4 event cycle", cyc, e);
        end
      end
    end
  end

  // driver: one detection, returns predicted event cycle
  task automatic fire(input int hold, output int e);
    int n;
    wait_armed();
    n = cyc;
    det = 1'b1;
    e = n + LAT;
    exp_q.push_back(e);
    repeat (hold) @(negedge clk);
    det = 1'b0;
  endtask

  task automatic follow(input int e, input bit noise_q, input bit noise_ld);
    wait_to(e);
    chk(evt && busy, "R5 busy at event", busy, 1);
    wait_to(e + 1);
    chk(!evt, "R4 single-cycle pulse", evt, 0);
    wait_to(e + RCT);
    chk(quench_en && !load_en, "R5 quench after reaction", quench_en, 1);
    if (noise_q) begin
      wait_to(e + RCT + 2);
      det = 1'b1;
      wait_to(e + RCT + 5);
      det = 1'b0;
    end
    wait_to(e + RCT + RCV - 1);
    chk(quench_en, "R6 quench held", quench_en, 1);
    wait_to(e + RCT + RCV);
    chk(!quench_en && load_en, "R6 recharge follows", load_en, 1);
    if (noise_ld) begin
      det = 1'b1;
      @(negedge clk);
      det = 1'b0;
    end
    wait_to(e + DEAD - 1);
    chk(load_en && busy, "R7 still blind", busy, 1);
    wait_to(e + DEAD);
    chk(!busy && !load_en && !quench_en, "R7 R11 re-armed", busy, 0);
    wait_to(e + DEAD + LAT + 4);
    chk(!busy, "R8 R9 armed and idle after noise", busy, 0);
    chk(exp_q.size() == 0, "R4 pending events", exp_q.size(), 0);
  endtask

  initial begin : main
    int e, e2, r;
    // R1: reset, with detect activity during reset
    repeat (2) @(negedge clk);
    det = 1'b1;
    repeat (2) @(negedge clk);
    chk(load_en && !quench_en && !evt && busy, "R1 reset state", load_en, 1);
    det = 1'b0;
    @(negedge clk);
    chk(load_en && !quench_en && !evt && busy, "R1 reset state after detect", busy, 1);
    rst = 1'b0;
    r = cyc;
    // R2
    wait_to(r + RCH - 1);
    chk(load_en && busy, "R2 recharge window", load_en, 1);
    wait_to(r + RCH);
    chk(!load_en && !busy && !quench_en, "R2 armed after recharge", busy, 0);
    wait_to(r + RCH + 5);
    chk(!evt && !busy, "R11 idle armed", busy, 0);

    // plain single-cycle detect
    fire(1, e);
    follow(e, 1'b0, 1'b0);
    // wider detect pulse plus noise during quench (R9)
    fire(3, e);
    follow(e, 1'b1, 1'b0);
    // noise during recharge (R8)
    fire(1, e);
    follow(e, 1'b0, 1'b1);
    // both kinds of noise
    fire(2, e);
    follow(e, 1'b1, 1'b1);

    // R10: detect held high
    wait_armed();
    det = 1'b1;
    e  = cyc + LAT;
    e2 = e + DEAD + LAT;
    exp_q.push_back(e);
    exp_q.push_back(e2);
    wait_to(e);
    chk(evt, "R10 first event", evt, 1);
    wait_to(e2);
    chk(evt, "R10 re-trigger spacing", evt, 1);
    det = 1'b0;
    wait_to(e2 + DEAD + LAT + 4);
    chk(!busy && exp_q.size() == 0, "R10 stops after release", busy, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule